// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a host a narrow window of four 64-bit registers through which it can reach a 32-bit internal peripheral bus. The host first loads a 32-bit data word (for writes), then writes a control word that carries the internal bus address, a byte count and a direction flag. That control write launches exactly one transfer on the internal request/response master port. When the internal response returns, the outcome is recorded in a status word that the host polls; read data comes back inside that status word, and reading the status clears it.

The transfer engine is a two-state machine. In `XS_IDLE` no request is outstanding; the transition *launch* (an accepted control write with a byte count of at most 8) latches the address, count, direction and data word and moves to `XS_BUSY`. In `XS_BUSY` the internal request is held steady; the transition *complete* (internal response seen) records the status and returns to `XS_IDLE`. A control write with a byte count above 8 takes no transition and leaves everything unchanged. While in `XS_BUSY`, the host port stalls any further control write; all other register accesses proceed.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the status and data registers read as zero, no internal request is raised and the host port is ready.
- R2: The register index is taken from host address bits [4:3] (0 control, 1 reset, 2 status, 3 data). A write to the data register stores bits [63:32] of the written value; reading it returns that value in bits [63:32] with bits [31:0] zero.
- R3: Reads of the control and reset registers return zero; writes to the status and reset registers change nothing.
- R4: Only accesses with a size of 8 bytes are valid; any other size is ignored (no register changes, status is not cleared) and a read returns zero.
- R5: An accepted control write launches one transfer: from the next cycle the request is raised with the address from bits [31:0], the byte count from bits [59:56], a read when bit 48 is set (write strobe low) and a write otherwise, carrying the data register value sampled at launch.
- R6: A control write with a byte count above 8 raises no request and leaves the status unchanged; a count of exactly 8 is accepted.
- R7: A read that completes without error leaves status with done at bit 11 and the 32 returned bits at [57:26], returned bits [31:24] (first byte) most significant.
- R8: A read that completes with an error leaves status with done at bit 11 and all ones in [57:26].
- R9: A completed write leaves status with only done at bit 11 set, whether or not the internal bus reported an error.
- R10: A status read returns the current value and clears it; if a completion lands in the same cycle, the read returns the old value and the completion value is kept.
- R11: While a transfer is outstanding the request and its fields stay stable, control writes are stalled (ready low) until the cycle after the response, and other registers stay accessible; data register writes during that time do not alter the in-flight write data.
- R12: An accepted host read returns its data with a valid strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request |
| h_we | input | 1 | Host access is a write |
| h_addr | input | ADDR_W | Host byte offset; bits [4:3] select the register |
| h_size | input | 4 | Host access size in bytes; only 8 is valid |
| h_wdata | input | 64 | Host write data |
| h_ready | output | 1 | Access accepted this cycle when high with h_req |
| h_rvalid | output | 1 | Read response valid |
| h_rdata | output | 64 | Read response data |
| m_req | output | 1 | Internal bus request, held until response |
| m_we | output | 1 | Internal request is a write |
| m_addr | output | 32 | Internal bus address |
| m_size | output | 4 | Internal transfer byte count |
| m_wdata | output | 32 | Internal write data, first byte in [31:24] |
| m_rsp | input | 1 | Internal response for the held request |
| m_err | input | 1 | Internal response reports failure |
| m_rdata | input | 32 | Internal read data, first byte in [31:24] |

## Verification
The two functions that can coincide are the host's read-and-clear of the status register and the completion of an internal transfer, which writes the same register. The bench provokes this by presenting a status read in exactly the cycle it drives the internal response, then judges that the read returned the previous (cleared) value and that a following status read returns the completion word. A second overlap, a stalled control write in the response cycle, is checked by watching ready rise only after the response and the queued transfer then launching with its own fields.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;

    localparam int REG_W          = 64;
    localparam int BUS_AW         = 32;
    localparam int BUS_DW         = 32;
    localparam int CNT_W          = 4;
    localparam int MAX_BYTES      = 8;
    localparam int HOST_ACC_BYTES = 8;
    localparam int IDX_LSB        = 3;
    localparam int CTL_RD_BIT     = 48;
    localparam int CTL_CNT_LSB    = 56;
    localparam int STAT_DONE_BIT  = 11;
    localparam int STAT_RD_LSB    = 26;
    localparam int DATA_LSB       = REG_W - BUS_DW;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_RST  = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_BUSY = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic              rd;
        logic              err;
        logic [BUS_DW-1:0] data;
    } cpl_t;

endpackage

// File: rtl/ind_bridge_host_if.sv
module ind_bridge_host_if
    import ind_bridge_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [CNT_W-1:0]  h_size,
    output logic              h_ready,
    output logic              h_rvalid,
    output logic [REG_W-1:0]  h_rdata,
    input  logic              busy,
    input  logic [REG_W-1:0]  stat_val,
    input  logic [BUS_DW-1:0] data_val,
    output logic              ctl_wr,
    output logic              data_wr,
    output logic              stat_rd
);

    reg_sel_e         sel;
    logic             size_ok;
    logic             is_ctl_wr;
    logic             acc;
    logic [REG_W-1:0] rd_mux;
    logic             unused_addr;

    assign sel         = reg_sel_e'(h_addr[IDX_LSB +: 2]);
    assign size_ok     = (h_size == CNT_W'(HOST_ACC_BYTES));
    assign is_ctl_wr   = h_req && h_we && size_ok && (sel == REG_CTL);
    assign unused_addr = ^{h_addr[ADDR_W-1:IDX_LSB+2], h_addr[IDX_LSB-1:0]};

    // Stall only a control write that would collide with an outstanding transfer
    assign h_ready = !(is_ctl_wr && busy);
    assign acc     = h_req && h_ready;

    assign ctl_wr  = acc && is_ctl_wr;
    assign data_wr = acc && h_we && size_ok && (sel == REG_DATA);
    assign stat_rd = acc && !h_we && size_ok && (sel == REG_STAT);

    always_comb begin
        rd_mux = '0;
        if (size_ok) begin
            unique case (sel)
                REG_CTL:  rd_mux = '0;
                REG_RST:  rd_mux = '0;
                REG_STAT: rd_mux = stat_val;
                REG_DATA: rd_mux = {data_val, {DATA_LSB{1'b0}}};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rvalid <= 1'b0;
            h_rdata  <= '0;
        end else begin
            h_rvalid <= acc && !h_we;
            if (acc && !h_we) begin
                h_rdata <= rd_mux;
            end
        end
    end

    p_bad_size_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_ready && !h_we && !size_ok) |=> (h_rdata == '0))
        else $error("bad-size read returned nonzero data");

endmodule

// File: rtl/ind_bridge_xfer_fsm.sv
module ind_bridge_xfer_fsm
    import ind_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [REG_W-1:0]  ctl_word,
    input  logic [BUS_DW-1:0] data_q,
    output logic              busy,
    output logic              m_req,
    output logic              m_we,
    output logic [BUS_AW-1:0] m_addr,
    output logic [CNT_W-1:0]  m_size,
    output logic [BUS_DW-1:0] m_wdata,
    input  logic              m_rsp,
    input  logic              m_err,
    input  logic [BUS_DW-1:0] m_rdata,
    output logic              cpl_valid,
    output cpl_t              cpl
);

    xfer_state_e       state_q;
    xfer_state_e       state_d;
    logic              req_rd;
    logic [CNT_W-1:0]  req_cnt;
    logic [BUS_AW-1:0] req_addr;
    logic              cnt_ok;
    logic              launch;
    logic              lat_rd;
    logic [CNT_W-1:0]  lat_cnt;
    logic [BUS_AW-1:0] lat_addr;
    logic [BUS_DW-1:0] lat_wdata;
    logic              unused_ctl;

    assign req_rd     = ctl_word[CTL_RD_BIT];
    assign req_cnt    = ctl_word[CTL_CNT_LSB +: CNT_W];
    assign req_addr   = ctl_word[BUS_AW-1:0];
    assign cnt_ok     = (req_cnt <= CNT_W'(MAX_BYTES));
    assign launch     = ctl_wr && cnt_ok;
    assign unused_ctl = ^{ctl_word[REG_W-1:CTL_CNT_LSB+CNT_W],
                          ctl_word[CTL_CNT_LSB-1:CTL_RD_BIT+1],
                          ctl_word[CTL_RD_BIT-1:BUS_AW]};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: launch (IDLE->BUSY), complete (BUSY->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_IDLE: if (launch) state_d = XS_BUSY;
            XS_BUSY: if (m_rsp)  state_d = XS_IDLE;
        endcase
    end

    // Launch latch: fields frozen for the whole outstanding transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_rd    <= 1'b0;
            lat_cnt   <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (launch && (state_q == XS_IDLE)) begin
            lat_rd    <= req_rd;
            lat_cnt   <= req_cnt;
            lat_addr  <= req_addr;
            lat_wdata <= data_q;
        end
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            XS_IDLE: begin
                busy      = 1'b0;
                m_req     = 1'b0;
                cpl_valid = 1'b0;
            end
            XS_BUSY: begin
                busy      = 1'b1;
                m_req     = 1'b1;
                cpl_valid = m_rsp;
            end
        endcase
    end

    assign m_we     = !lat_rd;
    assign m_addr   = lat_addr;
    assign m_size   = lat_cnt;
    assign m_wdata  = lat_wdata;
    assign cpl.rd   = lat_rd;
    assign cpl.err  = m_err;
    assign cpl.data = m_rdata;

    p_launch_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !busy && cnt_ok) |=>
            (m_req && m_addr == $past(req_addr) && m_we == !$past(req_rd)
             && m_size == $past(req_cnt)))
        else $error("launched request fields mismatch");

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !busy && !cnt_ok) |=> !m_req)
        else $error("oversized count raised a request");

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_rsp) |=>
            (m_req && $stable(m_addr) && $stable(m_we)
             && $stable(m_size) && $stable(m_wdata)))
        else $error("outstanding request changed before response");

endmodule

// File: rtl/ind_bridge_status.sv
module ind_bridge_status
    import ind_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_rd,
    input  logic             cpl_valid,
    input  cpl_t             cpl,
    output logic [REG_W-1:0] stat_q
);

    localparam logic [REG_W-1:0] DONE_W = REG_W'(1) << STAT_DONE_BIT;

    logic [REG_W-1:0] stat_d;
    logic [BUS_DW-1:0] rd_field;

    assign rd_field = cpl.err ? {BUS_DW{1'b1}} : cpl.data;

    // Completion outranks the clear: a same-cycle read sees the old value
    always_comb begin
        stat_d = stat_q;
        if (cpl_valid) begin
            if (cpl.rd) begin
                stat_d = DONE_W | (REG_W'(rd_field) << STAT_RD_LSB);
            end else begin
                stat_d = DONE_W;
            end
        end else if (stat_rd) begin
            stat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl.rd) |=> (stat_q == DONE_W))
        else $error("write completion status wrong");

    p_fail_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl.rd && cpl.err) |=>
            (stat_q[STAT_DONE_BIT] && (&stat_q[STAT_RD_LSB +: BUS_DW])))
        else $error("failed read did not report all ones");

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !cpl_valid) |=> (stat_q == '0))
        else $error("status not cleared after read");

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
    import ind_bridge_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [3:0]        h_size,
    input  logic [63:0]       h_wdata,
    output logic              h_ready,
    output logic              h_rvalid,
    output logic [63:0]       h_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [31:0]       m_addr,
    output logic [3:0]        m_size,
    output logic [31:0]       m_wdata,
    input  logic              m_rsp,
    input  logic              m_err,
    input  logic [31:0]       m_rdata
);

    logic              busy;
    logic              ctl_wr;
    logic              data_wr;
    logic              stat_rd;
    logic              cpl_valid;
    cpl_t              cpl;
    logic [REG_W-1:0]  stat_q;
    logic [BUS_DW-1:0] data_q;

    ind_bridge_host_if #(.ADDR_W(ADDR_W)) host_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_req    (h_req),
        .h_we     (h_we),
        .h_addr   (h_addr),
        .h_size   (h_size),
        .h_ready  (h_ready),
        .h_rvalid (h_rvalid),
        .h_rdata  (h_rdata),
        .busy     (busy),
        .stat_val (stat_q),
        .data_val (data_q),
        .ctl_wr   (ctl_wr),
        .data_wr  (data_wr),
        .stat_rd  (stat_rd)
    );

    // Data register: upper half of the host word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= h_wdata[REG_W-1:DATA_LSB];
        end
    end

    ind_bridge_xfer_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_word  (h_wdata),
        .data_q    (data_q),
        .busy      (busy),
        .m_req     (m_req),
        .m_we      (m_we),
        .m_addr    (m_addr),
        .m_size    (m_size),
        .m_wdata   (m_wdata),
        .m_rsp     (m_rsp),
        .m_err     (m_err),
        .m_rdata   (m_rdata),
        .cpl_valid (cpl_valid),
        .cpl       (cpl)
    );

    ind_bridge_status stat_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (stat_rd),
        .cpl_valid (cpl_valid),
        .cpl       (cpl),
        .stat_q    (stat_q)
    );

    p_stall_only_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_ready) |-> m_req)
        else $error("host stalled with no transfer outstanding");

    p_idle_after_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_rsp) |=> h_ready)
        else $error("host still stalled after response");

endmodule

// File: tb/ind_reg_bridge_tb_top.sv
module ind_reg_bridge_tb_top;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              h_req, h_we;
    logic [ADDR_W-1:0] h_addr;
    logic [3:0]        h_size;
    logic [63:0]       h_wdata;
    logic              h_ready, h_rvalid;
    logic [63:0]       h_rdata;
    logic              m_req, m_we;
    logic [31:0]       m_addr, m_wdata, m_rdata;
    logic [3:0]        m_size;
    logic              m_rsp, m_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ind_reg_bridge #(.ADDR_W(ADDR_W)) dut_i (.*);

    localparam logic [1:0] I_CTL = 2'd0, I_RST = 2'd1, I_STAT = 2'd2, I_DATA = 2'd3;
    localparam logic [63:0] DONE = 64'h800;

    function automatic logic [63:0] exp_rd(input logic [31:0] d);
        return (64'(d) << 26) | DONE;
    endfunction

    function automatic logic [63:0] ctl(input bit rd, input int cnt, input logic [31:0] a);
        return (64'(rd) << 48) | (64'(cnt[3:0]) << 56) | 64'(a);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit we, input logic [1:0] idx, input logic [63:0] d, input logic [3:0] sz);
        h_req   = 1'b1;
        h_we    = we;
        h_addr  = 12'h5A0 | ADDR_W'({idx, 3'b000});
        h_size  = sz;
        h_wdata = d;
    endtask

    task automatic hwr(input logic [1:0] idx, input logic [63:0] d, input logic [3:0] sz);
        @(negedge clk);
        drive(1'b1, idx, d, sz);
        #1;
        while (!h_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 h_req = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] idx, input logic [3:0] sz, output logic [63:0] d);
        @(negedge clk);
        drive(1'b0, idx, 64'h0, sz);
        #1;
        while (!h_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 h_req = 1'b0;
        @(negedge clk);
        chk("R12 rvalid", 64'(h_rvalid), 64'd1);
        d = h_rdata;
    endtask

    task automatic respond(input bit err, input logic [31:0] d);
        @(negedge clk);
        m_rsp = 1'b1; m_err = err; m_rdata = d;
        @(posedge clk);
        #1 m_rsp = 1'b0; m_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R1 ready", 64'(h_ready), 64'd1);
        chk("R1 no req", 64'(m_req), 64'd0);
        hrd(I_STAT, 4'd8, v); chk("R1 status", v, 64'h0);
        hrd(I_DATA, 4'd8, v); chk("R1 data", v, 64'h0);
    endtask

    task automatic t_regs();
        logic [63:0] v;
        hwr(I_DATA, 64'hA1B2C3D4_55667788, 4'd8);
        hrd(I_DATA, 4'd8, v); chk("R2 data readback", v, 64'hA1B2C3D4_00000000);
        hrd(I_CTL, 4'd8, v);  chk("R3 ctl reads zero", v, 64'h0);
        hrd(I_RST, 4'd8, v);  chk("R3 rst reads zero", v, 64'h0);
        hwr(I_DATA, 64'h99999999_00000000, 4'd4);
        hrd(I_DATA, 4'd8, v); chk("R4 bad-size write ignored", v, 64'hA1B2C3D4_00000000);
        hrd(I_DATA, 4'd4, v); chk("R4 bad-size read zero", v, 64'h0);
        hwr(I_CTL, ctl(1, 4, 32'h1234), 4'd2);
        #1 chk("R4 bad-size ctl no launch", 64'(m_req), 64'd0);
    endtask

    task automatic t_read_ok();
        logic [63:0] v;
        hwr(I_CTL, ctl(1, 4, 32'h1234_5678), 4'd8);
        chk("R5 req", 64'(m_req), 64'd1);
        chk("R5 read dir", 64'(m_we), 64'd0);
        chk("R5 addr", 64'(m_addr), 64'h1234_5678);
        chk("R5 size", 64'(m_size), 64'd4);
        respond(1'b0, 32'hDEADBEEF);
        hrd(I_STAT, 4'd4, v); chk("R4 bad-size status read zero", v, 64'h0);
        hwr(I_STAT, 64'h0, 4'd8);
        hwr(I_RST, 64'hFFFF_FFFF_FFFF_FFFF, 4'd8);
        hrd(I_STAT, 4'd8, v); chk("R7 read status (R3 R4 kept)", v, exp_rd(32'hDEADBEEF));
        hrd(I_STAT, 4'd8, v); chk("R10 cleared", v, 64'h0);
    endtask

    task automatic t_read_fail();
        logic [63:0] v;
        hwr(I_CTL, ctl(1, 2, 32'h0000_0080), 4'd8);
        respond(1'b1, 32'h0000_1111);
        hrd(I_STAT, 4'd8, v); chk("R8 fail ones", v, exp_rd(32'hFFFF_FFFF));
    endtask

    task automatic t_write();
        logic [63:0] v;
        hwr(I_DATA, 64'h11223344_DEAD0000, 4'd8);
        hwr(I_CTL, ctl(0, 4, 32'hC001_0040), 4'd8);
        chk("R5 write dir", 64'(m_we), 64'd1);
        chk("R5 wdata", 64'(m_wdata), 64'h11223344);
        hwr(I_DATA, 64'h55555555_00000000, 4'd8);
        chk("R11 wdata frozen", 64'(m_wdata), 64'h11223344);
        respond(1'b1, 32'h0);
        hrd(I_STAT, 4'd8, v); chk("R9 write err done only", v, DONE);
        hwr(I_CTL, ctl(0, 1, 32'h10), 4'd8);
        chk("R5 wdata new", 64'(m_wdata), 64'h55555555);
        respond(1'b0, 32'hFFFF_FFFF);
        hrd(I_STAT, 4'd8, v); chk("R9 write ok done only", v, DONE);
    endtask

    task automatic t_reject();
        logic [63:0] v;
        hwr(I_CTL, ctl(0, 3, 32'h20), 4'd8);
        respond(1'b0, 32'h0);
        hwr(I_CTL, ctl(1, 9, 32'h30), 4'd8);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 no req for count 9", 64'(m_req), 64'd0);
        end
        hrd(I_STAT, 4'd8, v); chk("R6 status unchanged", v, DONE);
        hwr(I_CTL, ctl(1, 8, 32'h40), 4'd8);
        chk("R6 count 8 accepted", 64'(m_req), 64'd1);
        chk("R6 count 8 size", 64'(m_size), 64'd8);
        respond(1'b0, 32'h0102_0304);
        hrd(I_STAT, 4'd8, v); chk("R7 byte order", v, exp_rd(32'h0102_0304));
    endtask

    task automatic t_stall();
        logic [63:0] v;
        hwr(I_CTL, ctl(1, 4, 32'hAAAA_0000), 4'd8);
        hrd(I_DATA, 4'd8, v); chk("R11 data readable while busy", v, 64'h55555555_00000000);
        @(negedge clk);
        drive(1'b1, I_CTL, ctl(1, 4, 32'hBBBB_0000), 4'd8);
        #1 chk("R11 ctl stalled", 64'(h_ready), 64'd0);
        m_rsp = 1'b1; m_err = 1'b0; m_rdata = 32'h0000_00AA;
        @(posedge clk);
        #1 m_rsp = 1'b0;
        chk("R11 ready after rsp", 64'(h_ready), 64'd1);
        @(posedge clk);
        #1 h_req = 1'b0;
        chk("R11 queued launch", 64'(m_req), 64'd1);
        chk("R11 queued addr", 64'(m_addr), 64'hBBBB_0000);
        respond(1'b0, 32'h0000_00BB);
        hrd(I_STAT, 4'd8, v); chk("R11 second result", v, exp_rd(32'h0000_00BB));
    endtask

    task automatic t_collide();
        logic [63:0] v;
        hwr(I_CTL, ctl(1, 4, 32'hCCCC_0000), 4'd8);
        @(negedge clk);
        drive(1'b0, I_STAT, 64'h0, 4'd8);
        m_rsp = 1'b1; m_err = 1'b0; m_rdata = 32'hCAFE_F00D;
        @(posedge clk);
        #1 h_req = 1'b0; m_rsp = 1'b0;
        @(negedge clk);
        chk("R10 same-cycle read old", h_rdata, 64'h0);
        hrd(I_STAT, 4'd8, v); chk("R10 completion kept", v, exp_rd(32'hCAFE_F00D));
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        rst_n = 1'b0;
        h_req = 1'b0; h_we = 1'b0; h_addr = '0; h_size = '0; h_wdata = '0;
        m_rsp = 1'b0; m_err = 1'b0; m_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_regs();
        t_read_ok();
        t_read_fail();
        t_write();
        t_reject();
        t_stall();
        t_collide();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule